// File: doc/BRIEF.md
# Event Timer with Comparator Channels

A memory-mapped event timer for system timekeeping. A 64-bit main counter advances by one every clock while the global run bit is set. A parameterised set of comparator channels watches it. Each channel raises an interrupt when the counter is exactly equal to its comparator. It does so once in one-shot mode. In periodic mode the comparator is advanced by a stored increment after every match, so the channel keeps firing at a fixed interval.

Software reaches everything through 32-bit word registers. These are an identification word, a tick-period word, a global control word, an interrupt status word, and the counter as two halves. Each channel also has a control word, a comparator word and two message-route words. A channel's event can leave the block in one of three ways: as a one-cycle pulse, as a held level, or as a single message write carrying a programmed data word to a programmed address. When legacy routing is on, channels 0 and 1 drive two dedicated legacy interrupt lines instead of their normal outputs.

Top module: `evt_timer_top`

## Requirements
- R1: Word 0 reads the channel count minus one in bits [4:0] and the legacy-routing capability in bit 8. Word 1 reads the counter tick period in femtoseconds.
- R2: The counter (words 4 and 5) increments by one per clock only while global control bit 0 (word 2) is set. Once it is cleared, the count holds.
- R3: Word 4 writes and reads the low 32 counter bits and word 5 the high 32 bits. A write to one half leaves the other half unchanged.
- R4: An enabled channel (control bit 0) whose control word has bits 2 and 5 clear fires when the running counter equals its comparator. It then gives a one-cycle pulse on its interrupt output in the cycle after the counter held that value. A comparator value the counter has already passed is not matched.
- R5: With control bit 4 set, a channel compares only the low counter half, so it fires again after the low half wraps. With bit 4 clear, the comparator is zero-extended and compared with all 64 bits.
- R6: Writing control bit 3 arms a one-shot load, and bit 3 always reads 0. The next comparator write loads the comparator and disarms. In periodic mode (bit 1), a comparator write made while disarmed loads the period increment instead and leaves the comparator unchanged.
- R7: In periodic mode, each match adds the period increment to the comparator, so pulses repeat every increment cycles.
- R8: In level mode (control bit 2 set), a match sets the channel's bit in status word 3 and holds the interrupt high. Writing 1 to that bit clears both. Writing 0 has no effect.
- R9: Control bit 8 (periodic capable) and bit 9 (message capable) are read-only. On a channel lacking the matching capability, writes to bit 1 or bit 5 are ignored.
- R10: When global control bit 1 is set, matches on channels 0 and 1 appear on legacy_o[0] and legacy_o[1], and irq_o[0] and irq_o[1] stay low.
- R11: A channel's route words sit at channel offsets +2 (data) and +3 (address). With control bit 5 set, a match gives a one-cycle msg_vld_o pulse carrying those words, with the same timing as an edge pulse, and no interrupt.
- R12: A comparator write takes effect two clocks after the clock edge that accepts it. Reads in between return the old value.
- R13: After reset the counter, control words, status and all outputs are zero, apart from the read-only capability bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write when 1, read when 0 |
| addr_i | input | ADDR_W | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | N_CH | Per-channel interrupt (pulse or level) |
| legacy_o | output | 2 | Legacy lines for channels 0 and 1 |
| msg_vld_o | output | N_CH | Per-channel message write request |
| msg_addr_o | output | 32*N_CH | Message address, channel i at bits [32i+31:32i] |
| msg_data_o | output | 32*N_CH | Message data, channel i at bits [32i+31:32i] |

## Verification
The bench builds the block with three channels. The periodic-capability mask is 3'b011 and the message-capability mask is 3'b110, with legacy routing available. This mix gives one channel lacking each capability, so the read-only bits and the ignored enable writes of R9 can be observed. Channel 1 has both capabilities, so it serves the periodic and message cases, and channel 2 serves level mode. Channels 0 and 1 both exist, so the two legacy lines of R10 can be exercised.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int DW = 32;

  // global word offsets; counter halves must be adjacent
  localparam int OFS_ID     = 0;
  localparam int OFS_PERIOD = 1;
  localparam int OFS_GCFG   = 2;
  localparam int OFS_STAT   = 3;
  localparam int OFS_CNT_LO = 4;
  localparam int OFS_CNT_HI = 5;
  localparam int CH_BASE    = 8;
  localparam int CH_STRIDE  = 4;

  localparam int SUB_CFG   = 0;
  localparam int SUB_CMP   = 1;
  localparam int SUB_MDATA = 2;
  localparam int SUB_MADDR = 3;

  // channel control bits
  localparam int B_EN   = 0;
  localparam int B_PER  = 1;
  localparam int B_LVL  = 2;
  localparam int B_SET  = 3;
  localparam int B_W32  = 4;
  localparam int B_MSG  = 5;
  localparam int B_PCAP = 8;
  localparam int B_MCAP = 9;

  typedef struct packed {
    logic en;
    logic per;
    logic lvl;
    logic w32;
    logic msg;
  } ch_cfg_t;

  typedef enum logic {POST_CMP = 1'b0, POST_PER = 1'b1} post_kind_e;
endpackage

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter int HALF_W = 32,
  localparam int CNT_W = 2 * HALF_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [HALF_W-1:0] wdata_i,
  output logic [CNT_W-1:0]  cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) cnt_d[HALF_W-1:0]     = wdata_i;
      if (wr_hi_i) cnt_d[CNT_W-1:HALF_W] = wdata_i;
    end else if (run_i) begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign cnt_o = cnt_q;

  assert_cnt_frozen_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !wr_lo_i && !wr_hi_i) |=> $stable(cnt_q));
  assert_cnt_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !wr_lo_i && !wr_hi_i) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/evt_channel.sv
module evt_channel
  import evt_timer_pkg::*;
#(
  parameter bit PER_CAP = 1'b1,
  parameter bit MSG_CAP = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [2*DW-1:0] cnt_i,
  input  logic            run_i,
  input  logic            cfg_we_i,
  input  logic            cmp_we_i,
  input  logic            mdata_we_i,
  input  logic            maddr_we_i,
  input  logic [DW-1:0]   wdata_i,
  input  logic            stat_clr_i,
  output logic [DW-1:0]   cfg_o,
  output logic [DW-1:0]   cmp_o,
  output logic [DW-1:0]   mdata_o,
  output logic [DW-1:0]   maddr_o,
  output logic            irq_o,
  output logic            stat_o,
  output logic            msg_vld_o
);
  ch_cfg_t     cfg_q;
  logic        arm_q;
  logic [DW-1:0] cmp_q, per_q, mdata_q, maddr_q;
  logic        p1_vld, p2_vld;
  logic [DW-1:0] p1_data, p2_data;
  post_kind_e  p1_kind, p2_kind;
  logic        hi_zero, lo_eq, hit, fire;
  logic        pulse_q, stat_q, msg_q;
  logic        post_cmp, post_per;

  // control word and set-value arming
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cfg_q <= '0;
      arm_q <= 1'b0;
    end else if (cfg_we_i) begin
      cfg_q.en  <= wdata_i[B_EN];
      cfg_q.per <= wdata_i[B_PER] & PER_CAP;
      cfg_q.lvl <= wdata_i[B_LVL];
      cfg_q.w32 <= wdata_i[B_W32];
      cfg_q.msg <= wdata_i[B_MSG] & MSG_CAP;
      if (wdata_i[B_SET]) arm_q <= 1'b1;
    end else if (cmp_we_i) begin
      arm_q <= 1'b0;
    end

  // two-stage posting of comparator writes; target decided at accept time
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      p1_vld  <= 1'b0;
      p2_vld  <= 1'b0;
      p1_data <= '0;
      p2_data <= '0;
      p1_kind <= POST_CMP;
      p2_kind <= POST_CMP;
    end else begin
      p1_vld  <= cmp_we_i;
      p1_data <= wdata_i;
      p1_kind <= (arm_q || !cfg_q.per) ? POST_CMP : POST_PER;
      p2_vld  <= p1_vld;
      p2_data <= p1_data;
      p2_kind <= p1_kind;
    end

  assign post_cmp = p2_vld && (p2_kind == POST_CMP);
  assign post_per = p2_vld && (p2_kind == POST_PER);

  // pure equality match, wraps with the counter
  assign hi_zero = (cnt_i[2*DW-1:DW] == '0);
  assign lo_eq   = (cnt_i[DW-1:0] == cmp_q);
  assign hit     = lo_eq && (cfg_q.w32 || hi_zero);
  assign fire    = cfg_q.en && run_i && hit;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cmp_q <= '0;
      per_q <= '0;
    end else begin
      if (post_cmp)                  cmp_q <= p2_data;
      else if (fire && cfg_q.per)    cmp_q <= cmp_q + per_q;
      if (post_per)                  per_q <= p2_data;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      mdata_q <= '0;
      maddr_q <= '0;
    end else begin
      if (mdata_we_i) mdata_q <= wdata_i;
      if (maddr_we_i) maddr_q <= wdata_i;
    end

  // event delivery
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      pulse_q <= 1'b0;
      stat_q  <= 1'b0;
      msg_q   <= 1'b0;
    end else begin
      pulse_q <= fire && !cfg_q.lvl && !cfg_q.msg;
      msg_q   <= fire && cfg_q.msg;
      if (fire && cfg_q.lvl && !cfg_q.msg) stat_q <= 1'b1;
      else if (stat_clr_i)                 stat_q <= 1'b0;
    end

  always_comb begin
    cfg_o         = '0;
    cfg_o[B_EN]   = cfg_q.en;
    cfg_o[B_PER]  = cfg_q.per;
    cfg_o[B_LVL]  = cfg_q.lvl;
    cfg_o[B_W32]  = cfg_q.w32;
    cfg_o[B_MSG]  = cfg_q.msg;
    cfg_o[B_PCAP] = PER_CAP;
    cfg_o[B_MCAP] = MSG_CAP;
  end

  assign cmp_o     = cmp_q;
  assign mdata_o   = mdata_q;
  assign maddr_o   = maddr_q;
  assign irq_o     = pulse_q | stat_q;
  assign stat_o    = stat_q;
  assign msg_vld_o = msg_q;

  assert_edge_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !cfg_q.lvl && !cfg_q.msg) |=> irq_o);
  assert_periodic_add_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cfg_q.per && !post_cmp) |=> (cmp_q == $past(cmp_q + per_q)));
  assert_level_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_q && !stat_clr_i) |=> stat_q);
  assert_msg_only_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && cfg_q.msg) |=> (msg_vld_o && !irq_o));
  assert_post_delay_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_cmp |=> (cmp_q == $past(p2_data)));
endmodule

// File: rtl/evt_timer_top.sv
// N_CH must be at least 2 (legacy lines) and fit the word address space.
module evt_timer_top
  import evt_timer_pkg::*;
#(
  parameter int              N_CH       = 3,
  parameter int              ADDR_W     = 6,
  parameter logic [DW-1:0]   PERIOD_FS  = 32'd69841279,
  parameter bit              LEGACY_CAP = 1'b1,
  parameter logic [N_CH-1:0] PER_CAP    = '1,
  parameter logic [N_CH-1:0] MSG_CAP    = '1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_i,
  input  logic               we_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [DW-1:0]      wdata_i,
  output logic [DW-1:0]      rdata_o,
  output logic [N_CH-1:0]    irq_o,
  output logic [1:0]         legacy_o,
  output logic [N_CH-1:0]    msg_vld_o,
  output logic [N_CH*DW-1:0] msg_addr_o,
  output logic [N_CH*DW-1:0] msg_data_o
);
  localparam int N_LEG = 2;

  logic            wr;
  logic            run_q, leg_q;
  logic [2*DW-1:0] cnt;
  logic [N_CH-1:0] ch_irq, ch_stat, stat_clr;
  logic [DW-1:0]   ch_cfg   [N_CH];
  logic [DW-1:0]   ch_cmp   [N_CH];
  logic [DW-1:0]   ch_mdata [N_CH];
  logic [DW-1:0]   ch_maddr [N_CH];
  logic [DW-1:0]   id_word;

  assign wr = req_i && we_i;
  assign id_word = {{(DW-9){1'b0}}, LEGACY_CAP, 3'b000, 5'(N_CH - 1)};

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      run_q <= 1'b0;
      leg_q <= 1'b0;
    end else if (wr && addr_i == ADDR_W'(OFS_GCFG)) begin
      run_q <= wdata_i[0];
      leg_q <= wdata_i[1] & LEGACY_CAP;
    end

  assign stat_clr = (wr && addr_i == ADDR_W'(OFS_STAT)) ? wdata_i[N_CH-1:0] : '0;

  evt_counter #(.HALF_W(DW)) i_counter (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run_q),
    .wr_lo_i (wr && addr_i == ADDR_W'(OFS_CNT_LO)),
    .wr_hi_i (wr && addr_i == ADDR_W'(OFS_CNT_HI)),
    .wdata_i (wdata_i),
    .cnt_o   (cnt)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    localparam int CB = CH_BASE + CH_STRIDE * i;

    evt_channel #(.PER_CAP(PER_CAP[i]), .MSG_CAP(MSG_CAP[i])) i_channel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .cnt_i      (cnt),
      .run_i      (run_q),
      .cfg_we_i   (wr && addr_i == ADDR_W'(CB + SUB_CFG)),
      .cmp_we_i   (wr && addr_i == ADDR_W'(CB + SUB_CMP)),
      .mdata_we_i (wr && addr_i == ADDR_W'(CB + SUB_MDATA)),
      .maddr_we_i (wr && addr_i == ADDR_W'(CB + SUB_MADDR)),
      .wdata_i    (wdata_i),
      .stat_clr_i (stat_clr[i]),
      .cfg_o      (ch_cfg[i]),
      .cmp_o      (ch_cmp[i]),
      .mdata_o    (ch_mdata[i]),
      .maddr_o    (ch_maddr[i]),
      .irq_o      (ch_irq[i]),
      .stat_o     (ch_stat[i]),
      .msg_vld_o  (msg_vld_o[i])
    );

    assign msg_addr_o[i*DW +: DW] = ch_maddr[i];
    assign msg_data_o[i*DW +: DW] = ch_mdata[i];

    if (i < N_LEG) begin : g_leg
      assign irq_o[i]    = ch_irq[i] & ~leg_q;
      assign legacy_o[i] = ch_irq[i] & leg_q;
    end else begin : g_plain
      assign irq_o[i] = ch_irq[i];
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADDR_W'(OFS_ID):     rdata_o = id_word;
      ADDR_W'(OFS_PERIOD): rdata_o = PERIOD_FS;
      ADDR_W'(OFS_GCFG):   rdata_o = {{(DW-2){1'b0}}, leg_q, run_q};
      ADDR_W'(OFS_STAT):   rdata_o = DW'(ch_stat);
      ADDR_W'(OFS_CNT_LO): rdata_o = cnt[DW-1:0];
      ADDR_W'(OFS_CNT_HI): rdata_o = cnt[2*DW-1:DW];
      default: begin
        for (int i = 0; i < N_CH; i++) begin
          if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE*i + SUB_CFG))   rdata_o = ch_cfg[i];
          if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE*i + SUB_CMP))   rdata_o = ch_cmp[i];
          if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE*i + SUB_MDATA)) rdata_o = ch_mdata[i];
          if (addr_i == ADDR_W'(CH_BASE + CH_STRIDE*i + SUB_MADDR)) rdata_o = ch_maddr[i];
        end
      end
    endcase
  end

  assert_cnt_lo_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFS_CNT_LO)) |=> (cnt[DW-1:0] == $past(wdata_i)));
  assert_legacy_route_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (leg_q && ch_irq[0]) |-> (legacy_o[0] && !irq_o[0]));
endmodule

// File: tb/test_evt_timer_top.sv
module test_evt_timer_top;
  localparam int NC = 3;
  localparam int A_ID = 0, A_PER = 1, A_GCFG = 2, A_STAT = 3, A_CLO = 4, A_CHI = 5;
  localparam logic [31:0] PFS = 32'd69841279;

  function automatic int ach(input int ch, input int sub);
    return 8 + 4 * ch + sub;
  endfunction

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [NC-1:0] irq, mvld;
  logic [1:0] leg;
  logic [NC*32-1:0] maddr, mdata;

  always #4 clk = ~clk;

  evt_timer_top #(.N_CH(NC), .ADDR_W(6), .PERIOD_FS(PFS), .LEGACY_CAP(1'b1),
                  .PER_CAP(3'b011), .MSG_CAP(3'b110)) i_evt_timer_top (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .legacy_o(leg),
    .msg_vld_o(mvld), .msg_addr_o(maddr), .msg_data_o(mdata));

  int n_chk = 0, n_err = 0;
  int cyc = 0;
  int irq_cnt [NC];
  int irq_t [NC][8];
  int leg_cnt [2];
  int leg_t [2];
  int msg_cnt [NC];
  int msg_t [NC];
  logic [31:0] msg_d [NC];
  logic [31:0] msg_a [NC];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    for (int i = 0; i < NC; i++) begin
      if (irq[i]) begin
        if (irq_cnt[i] < 8) irq_t[i][irq_cnt[i]] = cyc;
        irq_cnt[i] = irq_cnt[i] + 1;
      end
      if (mvld[i]) begin
        msg_cnt[i] = msg_cnt[i] + 1;
        msg_t[i] = cyc;
        msg_d[i] = mdata[i*32 +: 32];
        msg_a[i] = maddr[i*32 +: 32];
      end
    end
    for (int i = 0; i < 2; i++)
      if (leg[i]) begin
        leg_cnt[i] = leg_cnt[i] + 1;
        leg_t[i] = cyc;
      end
  end

  task automatic clear_logs();
    for (int i = 0; i < NC; i++) begin
      irq_cnt[i] = 0; msg_cnt[i] = 0; msg_t[i] = 0;
      for (int k = 0; k < 8; k++) irq_t[i][k] = 0;
    end
    for (int i = 0; i < 2; i++) begin leg_cnt[i] = 0; leg_t[i] = 0; end
  endtask

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    addr = 6'(a); wdata = d; req = 1'b1; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    addr = 6'(a);
    #1 d = rdata;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // stop, zero counter
  task automatic halt_zero();
    wr(A_GCFG, 32'h0);
    wr(A_CLO, 32'h0);
    wr(A_CHI, 32'h0);
  endtask

  localparam int NV = 5;
  localparam logic [31:0] V_CMP [NV] = '{32'd0, 32'd1, 32'd5, 32'd17, 32'd40};
  localparam logic [31:0] V_CFG [NV] = '{32'h01, 32'h11, 32'h01, 32'h11, 32'h01};

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] d, d2;
    int t0;
    clear_logs();
    wait_cyc(4);
    rst_ni = 1'b1;
    wait_cyc(2);

    // R13 reset state
    chk("R13 irq", irq, 0);
    chk("R13 legacy", leg, 0);
    chk("R13 msg", mvld, 0);
    rd(A_CLO, d); chk("R13 cnt", d, 0);
    rd(A_STAT, d); chk("R13 stat", d, 0);
    rd(ach(0, 0), d); chk("R13 ch0 cfg", d, 32'h100);

    // R1
    rd(A_ID, d); chk("R1 id", d, 32'h102);
    rd(A_PER, d); chk("R1 period", d, PFS);

    // R9 capability bits and ignored enables
    rd(ach(2, 0), d); chk("R9 ch2 caps", d, 32'h200);
    wr(ach(2, 0), 32'h23);
    rd(ach(2, 0), d); chk("R9 ch2 periodic ignored", d, 32'h221);
    wr(ach(0, 0), 32'h320);
    rd(ach(0, 0), d); chk("R9 ch0 msg ignored", d, 32'h100);
    wr(ach(2, 0), 32'h0);

    // R3 halves
    wr(A_CHI, 32'h12345678);
    wr(A_CLO, 32'h9abcdef0);
    rd(A_CHI, d); chk("R3 hi", d, 32'h12345678);
    rd(A_CLO, d); chk("R3 lo", d, 32'h9abcdef0);

    // R2 run and freeze
    wr(A_GCFG, 32'h1);
    wait_cyc(10);
    rd(A_CLO, d); chk("R2 count", d, 32'h9abcdefa);
    wr(A_GCFG, 32'h0);
    rd(A_CLO, d);
    wait_cyc(6);
    rd(A_CLO, d2); chk("R2 frozen", d2, d);
    rd(A_CHI, d); chk("R2 hi kept", d, 32'h12345678);

    // R4 vector walk
    for (int v = 0; v < NV; v++) begin
      halt_zero();
      wr(ach(0, 0), V_CFG[v]);
      wr(ach(0, 1), V_CMP[v]);
      wait_cyc(3);
      clear_logs();
      wr(A_GCFG, 32'h1);
      t0 = cyc;
      wait_cyc(int'(V_CMP[v]) + 5);
      chk("R4 pulse count", irq_cnt[0], 1);
      chk("R4 pulse cycle", irq_t[0][0], t0 + int'(V_CMP[v]) + 1);
    end

    // R4 passed value missed
    halt_zero();
    wr(A_CLO, 32'd100);
    wr(ach(0, 0), 32'h1);
    wr(ach(0, 1), 32'd50);
    wait_cyc(3);
    clear_logs();
    wr(A_GCFG, 32'h1);
    wait_cyc(60);
    chk("R4 passed value missed", irq_cnt[0], 0);

    // R5 32-bit compare across low wrap
    halt_zero();
    wr(A_CLO, 32'hFFFF_FFF0);
    wr(ach(0, 0), 32'h11);
    wr(ach(0, 1), 32'd2);
    wait_cyc(3);
    clear_logs();
    wr(A_GCFG, 32'h1);
    t0 = cyc;
    wait_cyc(30);
    chk("R5 w32 count", irq_cnt[0], 1);
    chk("R5 w32 cycle", irq_t[0][0], t0 + 19);
    halt_zero();
    wr(A_CLO, 32'hFFFF_FFF0);
    wr(ach(0, 0), 32'h01);
    wait_cyc(3);
    clear_logs();
    wr(A_GCFG, 32'h1);
    wait_cyc(30);
    chk("R5 64-bit no match", irq_cnt[0], 0);

    // R12 posting delay
    wr(A_GCFG, 32'h0);
    wr(ach(0, 1), 32'h55);
    rd(ach(0, 1), d); chk("R12 old after accept", d, 32'd2);
    wait_cyc(1);
    rd(ach(0, 1), d); chk("R12 old one clock on", d, 32'd2);
    wait_cyc(1);
    rd(ach(0, 1), d); chk("R12 new two clocks on", d, 32'h55);
    wr(ach(0, 0), 32'h0);

    // R6 / R7 periodic on ch1
    halt_zero();
    wr(ach(1, 0), 32'h0B);
    wr(ach(1, 1), 32'd10);
    wr(ach(1, 1), 32'd7);
    wait_cyc(3);
    rd(ach(1, 1), d); chk("R6 set-value loads compare", d, 32'd10);
    rd(ach(1, 0), d); chk("R6 set bit reads zero", d[3], 0);
    clear_logs();
    wr(A_GCFG, 32'h1);
    t0 = cyc;
    wait_cyc(30);
    chk("R7 first", irq_t[1][0], t0 + 11);
    chk("R7 second", irq_t[1][1], t0 + 18);
    chk("R7 third", irq_t[1][2], t0 + 25);
    wr(A_GCFG, 32'h0);
    rd(ach(1, 1), d);
    wr(ach(1, 1), 32'd99);
    wait_cyc(3);
    rd(ach(1, 1), d2); chk("R6 disarmed write keeps compare", d2, d);

    // R8 level on ch2
    wr(ach(1, 0), 32'h0);
    halt_zero();
    wr(ach(2, 0), 32'h5);
    wr(ach(2, 1), 32'd3);
    wait_cyc(3);
    wr(A_GCFG, 32'h1);
    wait_cyc(10);
    chk("R8 level high", irq[2], 1);
    rd(A_STAT, d); chk("R8 status set", d, 32'h4);
    wait_cyc(5);
    wr(A_STAT, 32'h3);
    chk("R8 write zero no effect", irq[2], 1);
    rd(A_STAT, d); chk("R8 status kept", d, 32'h4);
    wr(A_STAT, 32'h4);
    chk("R8 cleared irq", irq[2], 0);
    rd(A_STAT, d); chk("R8 cleared status", d, 32'h0);
    wr(ach(2, 0), 32'h0);

    // R10 legacy routing
    halt_zero();
    wr(ach(0, 0), 32'h1);
    wr(ach(0, 1), 32'd4);
    wait_cyc(3);
    clear_logs();
    wr(A_GCFG, 32'h3);
    t0 = cyc;
    wait_cyc(12);
    rd(A_GCFG, d); chk("R10 gcfg", d, 32'h3);
    chk("R10 legacy count", leg_cnt[0], 1);
    chk("R10 legacy cycle", leg_t[0], t0 + 5);
    chk("R10 irq0 quiet", irq_cnt[0], 0);
    wr(ach(0, 0), 32'h0);

    // R11 message delivery on ch1
    halt_zero();
    wr(ach(1, 0), 32'h21);
    wr(ach(1, 2), 32'hCAFE_0001);
    wr(ach(1, 3), 32'hFEE0_0010);
    wr(ach(1, 1), 32'd6);
    wait_cyc(3);
    clear_logs();
    wr(A_GCFG, 32'h1);
    t0 = cyc;
    wait_cyc(12);
    chk("R11 msg count", msg_cnt[1], 1);
    chk("R11 msg cycle", msg_t[1], t0 + 7);
    chk("R11 msg data", msg_d[1], 32'hCAFE_0001);
    chk("R11 msg addr", msg_a[1], 32'hFEE0_0010);
    chk("R11 no irq", irq_cnt[1], 0);

    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule